// File: doc/BRIEF.md
# MMU Fault Cause Encoder

This block sits beside an address-translation unit. When a translation attempt fails, the translation logic presents the failure kind, whether the access was an instruction fetch or a data access, whether a data access was a write, and the effective address. It also pulses a one-cycle capture strobe. The encoder turns that outcome into the architected fault status values and holds them for the exception logic. The page-table walk itself and the dispatch of the exception are outside this block.

A data fault loads two registers: a data fault status word with one-hot cause bits, and a data fault address register. An instruction fault loads an instruction cause word, which the exception logic merges into the saved machine state. Each valid capture also records the exception class. A segment-table miss is reported through its own segment exception class, with a zero cause code. A combination of failure kind and access type that has no architected meaning raises an invalid flag and disturbs no register.

Top module: `mmu_fault_cause_enc`

## Requirements
- R1: While `rst_n` is low, all outputs are zero: status, address, instruction cause, class 0 (none) and invalid flag.
- R2: Failure kind 0 (no page-table match) gives cause word 0x40000000. This applies to data accesses (`ifetch_i`=0, into the data status word) and to fetches (`ifetch_i`=1, into the instruction cause word).
- R3: Failure kind 1 (protection violation) gives cause word 0x08000000, for data accesses and for fetches alike.
- R4: On a fetch, failure kind 2 (no-execute) and failure kind 3 (fetch from a direct-store area) both give cause word 0x10000000.
- R5: On a data access, failure kind 4 (load-reserve or store-conditional to direct-store) gives 0x04000000. Failure kind 5 (external-control access to direct-store) gives 0x04100000.
- R6: For data kinds 0, 1, 4 and 5 with `write_i`=1, bit 0x02000000 is ORed into the data status word. It is never set for a segment miss.
- R7: A valid data capture writes `addr_i` into the address register and the code into the status register, and leaves the instruction cause unchanged. A valid fetch capture writes only the instruction cause and leaves both data registers unchanged.
- R8: Failure kind 6 (segment-table miss) gives class 3 (instruction segment) on a fetch and class 4 (data segment) on a data access, with a cause code of zero. A data segment miss still captures the address.
- R9: In a cycle without `capture_i`, no output changes.
- R10: An invalid combination leaves all status, address, cause and class outputs unchanged and sets `invalid_o` until the next valid capture clears it. The invalid combinations are kind 7 with either access type, kinds 4 and 5 on a fetch, and kinds 2 and 3 on a data access.
- R11: A valid non-segment capture sets the class to 1 (instruction storage) for a fetch and to 2 (data storage) for a data access. All outputs appear one clock after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_i | input | 1 | One-cycle strobe: capture the fault presented |
| ifetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| write_i | input | 1 | 1 = data write |
| fault_kind_i | input | 3 | Failure kind, encoded as in R2 to R10 |
| addr_i | input | ADDR_W | Faulting effective address |
| dstat_o | output | 32 | Data fault status word |
| daddr_o | output | ADDR_W | Data fault address |
| icause_o | output | 32 | Instruction fault cause word |
| class_o | output | 3 | Exception class of last valid capture |
| invalid_o | output | 1 | Last capture had an invalid kind |

## Verification
The bench goes after the combinations that share one code or that must not share one.

The first pair is no-execute and direct-store fetches, which must give the same bit. A design that decoded them apart would report the wrong cause. The second pair is reservation and external-control accesses, which differ only in bit 0x00100000.

The store bit must appear on data storage faults but not on data segment misses. A design that ORed it in regardless would report a non-zero segment code.

Invalid combinations are interleaved with valid ones, so that a design which wrote its registers or failed to clear the flag on such a capture shows a mismatch on the very next check. Fetch faults follow data faults, so that a design that let one side write the other's registers is exposed.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int CAUSE_W = 32;

  localparam int BIT_NOMATCH = 30;
  localparam int BIT_NOEXEC  = 28;
  localparam int BIT_PROT    = 27;
  localparam int BIT_DSTORE  = 26;
  localparam int BIT_WRITE   = 25;
  localparam int BIT_EXTCTL  = 20;

  typedef enum logic [2:0] {
    FK_NOMATCH = 3'd0,
    FK_PROT    = 3'd1,
    FK_NOEXEC  = 3'd2,
    FK_DIRECT  = 3'd3,
    FK_RESV    = 3'd4,
    FK_EXTCTL  = 3'd5,
    FK_SEGMISS = 3'd6,
    FK_RSVD    = 3'd7
  } fault_kind_e;

  typedef enum logic [2:0] {
    XC_NONE  = 3'd0,
    XC_ISTOR = 3'd1,
    XC_DSTOR = 3'd2,
    XC_ISEG  = 3'd3,
    XC_DSEG  = 3'd4
  } exc_class_e;

  typedef struct packed {
    exc_class_e           cls;
    logic [CAUSE_W-1:0]   code;
    logic                 upd_data;
    logic                 upd_inst;
    logic                 bad;
  } fault_dec_t;
endpackage

// File: rtl/fce_decode.sv
module fce_decode
  import fce_pkg::*;
(
  input  fault_kind_e kind_i,
  input  logic        ifetch_i,
  input  logic        write_i,
  output fault_dec_t  dec_o
);
  logic [CAUSE_W-1:0] base_code;
  logic               storage_fault;

  always_comb begin
    base_code     = '0;
    storage_fault = 1'b0;
    dec_o         = '0;
    dec_o.cls     = XC_NONE;
    if (ifetch_i) begin
      unique case (kind_i)
        FK_NOMATCH: begin base_code[BIT_NOMATCH] = 1'b1; storage_fault = 1'b1; end
        FK_PROT:    begin base_code[BIT_PROT]    = 1'b1; storage_fault = 1'b1; end
        FK_NOEXEC,
        FK_DIRECT:  begin base_code[BIT_NOEXEC]  = 1'b1; storage_fault = 1'b1; end
        FK_SEGMISS: begin dec_o.cls = XC_ISEG; dec_o.upd_inst = 1'b1; end
        default:    dec_o.bad = 1'b1;
      endcase
      if (storage_fault) begin
        dec_o.cls      = XC_ISTOR;
        dec_o.upd_inst = 1'b1;
      end
      dec_o.code = base_code;
    end else begin
      unique case (kind_i)
        FK_NOMATCH: begin base_code[BIT_NOMATCH] = 1'b1; storage_fault = 1'b1; end
        FK_PROT:    begin base_code[BIT_PROT]    = 1'b1; storage_fault = 1'b1; end
        FK_RESV:    begin base_code[BIT_DSTORE]  = 1'b1; storage_fault = 1'b1; end
        FK_EXTCTL:  begin
          base_code[BIT_DSTORE] = 1'b1;
          base_code[BIT_EXTCTL] = 1'b1;
          storage_fault         = 1'b1;
        end
        FK_SEGMISS: begin dec_o.cls = XC_DSEG; dec_o.upd_data = 1'b1; end
        default:    dec_o.bad = 1'b1;
      endcase
      if (storage_fault) begin
        dec_o.cls      = XC_DSTOR;
        dec_o.upd_data = 1'b1;
        base_code[BIT_WRITE] = write_i;
      end
      dec_o.code = base_code;
    end
  end
endmodule

// File: rtl/fce_regs.sv
module fce_regs
  import fce_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  fault_dec_t         dec_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [CAUSE_W-1:0] dstat_o,
  output logic [ADDR_W-1:0]  daddr_o,
  output logic [CAUSE_W-1:0] icause_o,
  output exc_class_e         class_o,
  output logic               invalid_o
);
  logic [CAUSE_W-1:0] dstat_d, icause_d;
  logic [ADDR_W-1:0]  daddr_d;
  exc_class_e         class_d;
  logic               invalid_d;
  logic               en_data, en_inst, en_class, en_flag;

  always_comb begin
    en_data  = cap_i & dec_i.upd_data & ~dec_i.bad;
    en_inst  = cap_i & dec_i.upd_inst & ~dec_i.bad;
    en_class = cap_i & ~dec_i.bad;
    en_flag  = cap_i;
    dstat_d   = en_data  ? dec_i.code : dstat_o;
    daddr_d   = en_data  ? addr_i     : daddr_o;
    icause_d  = en_inst  ? dec_i.code : icause_o;
    class_d   = en_class ? dec_i.cls  : class_o;
    invalid_d = en_flag  ? dec_i.bad  : invalid_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstat_o   <= '0;
      daddr_o   <= '0;
      icause_o  <= '0;
      class_o   <= XC_NONE;
      invalid_o <= 1'b0;
    end else begin
      dstat_o   <= dstat_d;
      daddr_o   <= daddr_d;
      icause_o  <= icause_d;
      class_o   <= class_d;
      invalid_o <= invalid_d;
    end
  end
endmodule

// File: rtl/mmu_fault_cause_enc.sv
module mmu_fault_cause_enc
  import fce_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              ifetch_i,
  input  logic              write_i,
  input  logic [2:0]        fault_kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [31:0]       dstat_o,
  output logic [ADDR_W-1:0] daddr_o,
  output logic [31:0]       icause_o,
  output logic [2:0]        class_o,
  output logic              invalid_o
);
  fault_dec_t dec;
  exc_class_e cls_q;

  fce_decode u_decode (
    .kind_i   (fault_kind_e'(fault_kind_i)),
    .ifetch_i (ifetch_i),
    .write_i  (write_i),
    .dec_o    (dec)
  );

  fce_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (capture_i),
    .dec_i     (dec),
    .addr_i    (addr_i),
    .dstat_o   (dstat_o),
    .daddr_o   (daddr_o),
    .icause_o  (icause_o),
    .class_o   (cls_q),
    .invalid_o (invalid_o)
  );

  assign class_o = cls_q;
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              capture_i,
  input logic              ifetch_i,
  input logic              write_i,
  input logic [2:0]        fault_kind_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       dstat_o,
  input logic [ADDR_W-1:0] daddr_o,
  input logic [31:0]       icause_o,
  input logic [2:0]        class_o,
  input logic              invalid_o
);
  logic bad_combo, data_ok;
  always_comb begin
    bad_combo = (fault_kind_i == 3'd7) ||
                ( ifetch_i && (fault_kind_i == 3'd4 || fault_kind_i == 3'd5)) ||
                (!ifetch_i && (fault_kind_i == 3'd2 || fault_kind_i == 3'd3));
    data_ok   = !ifetch_i && !bad_combo;
  end

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(dstat_o) && $stable(daddr_o) && $stable(icause_o)
                   && $stable(class_o) && $stable(invalid_o));

  assert_data_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && data_ok |=> daddr_o == $past(addr_i) && $stable(icause_o));

  assert_fetch_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && ifetch_i |=> $stable(dstat_o) && $stable(daddr_o));

  assert_invalid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && bad_combo |=> invalid_o && $stable(dstat_o) && $stable(daddr_o)
                               && $stable(icause_o) && $stable(class_o));

  assert_seg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (class_o == 3'd3 |-> icause_o == 32'h0) and (class_o == 3'd4 |-> dstat_o == 32'h0));

  assert_one_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dstat_o & ~32'h0210_0000) <= 1);

  assert_store_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && data_ok && fault_kind_i != 3'd6 |=> dstat_o[25] == $past(write_i));
endmodule

bind mmu_fault_cause_enc fce_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .capture_i(capture_i), .ifetch_i(ifetch_i),
  .write_i(write_i), .fault_kind_i(fault_kind_i), .addr_i(addr_i),
  .dstat_o(dstat_o), .daddr_o(daddr_o), .icause_o(icause_o),
  .class_o(class_o), .invalid_o(invalid_o)
);

// File: tb/mmu_fault_cause_enc_tb.sv
module mmu_fault_cause_enc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              capture_i, ifetch_i, write_i;
  logic [2:0]        fault_kind_i;
  logic [ADDR_W-1:0] addr_i;
  logic [31:0]       dstat_o, icause_o;
  logic [ADDR_W-1:0] daddr_o;
  logic [2:0]        class_o;
  logic              invalid_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0]       m_dstat, m_icause;
  logic [ADDR_W-1:0] m_daddr;
  logic [2:0]        m_class;
  logic              m_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_cause_enc #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .capture_i(capture_i), .ifetch_i(ifetch_i),
    .write_i(write_i), .fault_kind_i(fault_kind_i), .addr_i(addr_i),
    .dstat_o(dstat_o), .daddr_o(daddr_o), .icause_o(icause_o),
    .class_o(class_o), .invalid_o(invalid_o)
  );

  function automatic string tag_of(logic cap, logic f, logic [2:0] k);
    if (!cap) return "R9";
    if (k == 3'd7 || (f && k >= 3'd4 && k <= 3'd5) || (!f && (k == 3'd2 || k == 3'd3)))
      return "R10";
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd6: return "R8";
      default: return "R5/R6";
    endcase
  endfunction

  task automatic model(logic f, logic w, logic [2:0] k, logic [ADDR_W-1:0] a);
    logic [31:0] code;
    logic        bad;
    bad  = 1'b0;
    code = 32'h0;
    if (f) begin
      case (k)
        3'd0: code = 32'h4000_0000;
        3'd1: code = 32'h0800_0000;
        3'd2, 3'd3: code = 32'h1000_0000;
        3'd6: code = 32'h0;
        default: bad = 1'b1;
      endcase
      if (!bad) begin
        m_icause = code;
        m_class  = (k == 3'd6) ? 3'd3 : 3'd1;
      end
    end else begin
      case (k)
        3'd0: code = 32'h4000_0000;
        3'd1: code = 32'h0800_0000;
        3'd4: code = 32'h0400_0000;
        3'd5: code = 32'h0410_0000;
        3'd6: code = 32'h0;
        default: bad = 1'b1;
      endcase
      if (!bad) begin
        if (k != 3'd6 && w) code = code | 32'h0200_0000;
        m_dstat = code;
        m_daddr = a;
        m_class = (k == 3'd6) ? 3'd4 : 3'd2;
      end
    end
    m_inv = bad;
  endtask

  task automatic compare(string tag);
    checks++;
    if (dstat_o !== m_dstat || daddr_o !== m_daddr || icause_o !== m_icause ||
        class_o !== m_class || invalid_o !== m_inv) begin
      fails++;
      $display("FAIL %s: got st=%h ad=%h ic=%h cl=%0d inv=%b exp st=%h ad=%h ic=%h cl=%0d inv=%b",
               tag, dstat_o, daddr_o, icause_o, class_o, invalid_o,
               m_dstat, m_daddr, m_icause, m_class, m_inv);
    end
  endtask

  task automatic step(logic cap, logic f, logic w, logic [2:0] k, logic [ADDR_W-1:0] a);
    capture_i = cap; ifetch_i = f; write_i = w; fault_kind_i = k; addr_i = a;
    @(negedge clk);
    if (cap) model(f, w, k, a);
    compare(tag_of(cap, f, k));
    capture_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0; capture_i = 1'b0; ifetch_i = 1'b0; write_i = 1'b0;
    fault_kind_i = 3'd0; addr_i = '0;
    m_dstat = '0; m_daddr = '0; m_icause = '0; m_class = 3'd0; m_inv = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    // Directed corner cases
    step(1, 0, 1, 3'd0, 32'hDEAD_0000);   // R2 data write, store bit R6
    step(1, 1, 0, 3'd0, 32'h1111_1111);   // R2 fetch, data regs kept R7
    step(1, 0, 0, 3'd1, 32'h2222_2222);   // R3 data read
    step(1, 1, 0, 3'd1, 32'h0);           // R3 fetch, R11 class
    step(1, 1, 0, 3'd2, 32'h0);           // R4 no-execute
    step(1, 1, 0, 3'd3, 32'h0);           // R4 direct-store fetch
    step(1, 0, 1, 3'd4, 32'h3333_3333);   // R5 reservation + R6
    step(1, 0, 0, 3'd5, 32'h4444_4444);   // R5 external-control
    step(1, 0, 1, 3'd6, 32'h5555_5555);   // R8 data seg, no store bit R6
    step(1, 1, 1, 3'd6, 32'h6666_6666);   // R8 fetch seg
    step(0, 0, 1, 3'd0, 32'h7777_7777);   // R9 no capture
    step(1, 0, 1, 3'd7, 32'h8888_8888);   // R10 reserved kind
    step(1, 1, 0, 3'd4, 32'h9999_9999);   // R10 fetch reservation
    step(1, 0, 0, 3'd2, 32'hAAAA_AAAA);   // R10 data no-execute
    step(1, 0, 0, 3'd0, 32'hBBBB_BBBB);   // R10 cleared by valid capture
    // Constrained random
    for (int i = 0; i < 600; i++) begin
      logic cap;
      cap = ($urandom % 10) < 7;
      step(cap, 1'($urandom), 1'($urandom), 3'($urandom), $urandom);
    end
    // Reset mid-run returns to zero state
    rst_n = 1'b0;
    m_dstat = '0; m_daddr = '0; m_icause = '0; m_class = 3'd0; m_inv = 1'b0;
    @(negedge clk);
    compare("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule